// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit operands over a run of clock cycles and returns a 64-bit product. It can treat the operands as unsigned or as two's complement. Only one adder, as wide as one operand, is needed. The multiplier operand is parked in the lower half of the product register and is used up one bit per step as the register shifts right. The partial sum grows into the upper half as the multiplier bits leave.

A client raises `start` for one cycle with the operands and the mode bit. It then waits for the one-cycle `done` pulse and reads the two product halves. The halves keep their value until the next accepted start.

For a signed request, the block works on the operand magnitudes. It records whether exactly one operand was negative, and if so it negates the final product on the last step.

Top module: `seq_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both product halves read 0.
- R2: With `signed_mode` = 0, the operands are unsigned (bit 31 is a magnitude bit). `{prod_hi, prod_lo}` equals their full 64-bit unsigned product.
- R3: With `signed_mode` = 1, the operands are two's complement. `{prod_hi, prod_lo}` equals their 64-bit two's complement product for every sign combination.
- R4: A start taken while idle raises `busy` on the next edge. `busy` then stays high for exactly 32 cycles, one per multiplier bit.
- R5: `done` is high for exactly one cycle: the first cycle after `busy` falls. `busy` is low while `done` is high.
- R6: A `start` that arrives while `busy` is high is ignored. The running operation keeps its operands and its timing.
- R7: The carry out of the upper-half addition is kept. An all-ones unsigned operand pair gives 0xFFFFFFFE00000001.
- R8: While idle with no start, the product halves do not change.
- R9: In signed mode, the most negative operand (0x80000000) is handled correctly, including when both operands are 0x80000000 (result 0x4000000000000000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiply; sampled only while idle |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| mcand_in | input | 32 | Multiplicand operand |
| mplier_in | input | 32 | Multiplier operand |
| busy | output | 1 | High while the 32 steps run |
| done | output | 1 | One-cycle pulse when the product is ready |
| prod_hi | output | 32 | Upper half of the product |
| prod_lo | output | 32 | Lower half of the product |

## Verification
Small unsigned operands confirm the basic add-and-shift sequence. All-ones operands produce a carry out of the upper-half adder on almost every step, so a dropped carry shows up at once.

Signed runs cover all four sign pairs, which separates a missing or misplaced final negation from a wrong magnitude step. The same bit patterns are also run in unsigned mode to show that bit 31 is read as magnitude there. Runs with 0x80000000 expose any magnitude path that overflows.

A second start injected in the middle of a run checks that new operands never reach the working registers.

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] mcand_in,
  input  logic [W-1:0] mplier_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]   mcand;
  logic [2*W-1:0] prod;
  logic [CW-1:0]  step;
  logic           neg;

  wire         a_neg  = signed_mode & mcand_in[W-1];
  wire         b_neg  = signed_mode & mplier_in[W-1];
  wire [W-1:0] a_mag  = a_neg ? (~mcand_in + 1'b1) : mcand_in;
  wire [W-1:0] b_mag  = b_neg ? (~mplier_in + 1'b1) : mplier_in;
  wire [W-1:0] addend = prod[0] ? mcand : {W{1'b0}};
  wire [W:0]   sum    = {1'b0, prod[2*W-1:W]} + {1'b0, addend};
  wire [2*W-1:0] shifted = {sum, prod[W-1:1]};
  wire         last   = (step == CW'(W - 1));

  assign prod_hi = prod[2*W-1:W];
  assign prod_lo = prod[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand <= '0;
      prod  <= '0;
      step  <= '0;
      neg   <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        mcand <= a_mag;
        prod  <= {{W{1'b0}}, b_mag};
        neg   <= a_neg ^ b_neg;
        step  <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        prod <= (last && neg) ? (~shifted + 1'b1) : shifted;
        step <= step + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/seq_mul_chk.sv
module seq_mul_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] prod_hi,
  input logic [W-1:0] prod_lo
);
  localparam int CW = $clog2(W + 2);
  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < CW'(W)));
  p_done_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == CW'(W)));
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_fall_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo)));
endmodule

bind seq_mul seq_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .prod_hi(prod_hi), .prod_lo(prod_lo)
);

// File: tb/sim_seq_mul.sv
module sim_seq_mul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed_mode = 1'b0;
  logic [31:0] mcand_in = '0;
  logic [31:0] mplier_in = '0;
  logic busy, done;
  logic [31:0] prod_hi, prod_lo;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  seq_mul u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .mcand_in(mcand_in), .mplier_in(mplier_in), .busy(busy), .done(done),
    .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic signed [63:0] sa, sb;
    if (s) begin
      sa = {{32{a[31]}}, a};
      sb = {{32{b[31]}}, b};
      return sa * sb;
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  task automatic kick(input logic [31:0] a, input logic [31:0] b, input logic s);
    @(negedge clk);
    mcand_in = a; mplier_in = b; signed_mode = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b, input logic s);
    int n;
    kick(a, b, s);
    n = 1;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk({req, " R4 latency"}, 64'(n), 64'd33);
    chk(req, {prod_hi, prod_lo}, model(a, b, s));
    @(negedge clk);
    chk({req, " R5 done pulse"}, 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 product", {prod_hi, prod_lo}, 64'd0);
  endtask

  task automatic t_unsigned;
    run_op("R2 small", 32'd6, 32'd5, 1'b0);
    run_op("R2 mixed", 32'h1234_5678, 32'h9ABC_DEF0, 1'b0);
    run_op("R2 msb magnitude", 32'hFFFF_FFFE, 32'd3, 1'b0);
    run_op("R2 zero", 32'd0, 32'hDEAD_BEEF, 1'b0);
  endtask

  task automatic t_carry;
    run_op("R7 all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_signed;
    run_op("R3 pos pos", 32'd7, 32'd9, 1'b1);
    run_op("R3 neg pos", 32'hFFFF_FFFA, 32'd7, 1'b1);
    run_op("R3 pos neg", 32'd3, 32'hFFFF_FFFB, 1'b1);
    run_op("R3 neg neg", 32'hFFFF_FFFE, 32'hFFFF_FFFD, 1'b1);
    run_op("R3 wide", 32'h8765_4321, 32'h1357_9BDF, 1'b1);
  endtask

  task automatic t_minneg;
    run_op("R9 min min", 32'h8000_0000, 32'h8000_0000, 1'b1);
    run_op("R9 min one", 32'h8000_0000, 32'd1, 1'b1);
    run_op("R9 min m1", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic t_ignore;
    int n;
    kick(32'd11, 32'd13, 1'b0);
    n = 1;
    repeat (4) begin @(negedge clk); n++; end
    mcand_in = 32'hFFFF_FFFF; mplier_in = 32'hFFFF_FFFF; signed_mode = 1'b1; start = 1'b1;
    @(negedge clk); n++;
    start = 1'b0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R6 timing kept", 64'(n), 64'd33);
    chk("R6 operands kept", {prod_hi, prod_lo}, 64'd143);
    @(negedge clk);
    chk("R6 no restart", 64'(busy), 64'd0);
  endtask

  task automatic t_hold;
    logic [63:0] snap;
    snap = {prod_hi, prod_lo};
    mcand_in = 32'h5555_5555; mplier_in = 32'hAAAA_AAAA;
    repeat (6) @(negedge clk);
    chk("R8 hold", {prod_hi, prod_lo}, snap);
    chk("R8 idle", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_carry();
    t_signed();
    t_minneg();
    t_ignore();
    t_hold();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule